// File: doc/BRIEF.md
# Chainable Column Line-Load Sequencer

This block controls how one line of display data is loaded into a column driver that sits in a chain with other identical drivers. A start pulse arrives on the data clock. From the next clock onward, each clock delivers a wide bus that holds several grayscale codes side by side. The block writes those codes into the next group of column slots of a line buffer. The fill runs from the first column upward or from the last column downward.

A little before its own buffer is full, the block raises a one-clock enable pulse for the next driver in the chain. That driver can then take over the bus with no gap between the two. The interface may send each code with its low half, its high half, or both halves inverted to cut bus toggling. The block restores the true code before it stores it.

A direction pin chooses which of the two enable pin pairs acts as the input and which as the output. It also chooses the fill order. Once a line has started, the block holds the direction it sampled for the rest of that line. The buffer has one combinational read port for the stage that follows it.

Top module: `colfill_seq`

## Requirements
- R1: While reset is asserted and right after it, both enable outputs are low and `line_done` is low. The pin pair chosen by `dir_in` is output-enabled.
- R2: The start pulse is sampled on a rising clock edge, counted as clock 1. Nothing is written on clock 1. Group 0 is written on clock 2, using the bus value present at that edge.
- R3: On each clock from 2 to GROUPS+1, one group g (g = 0, 1, ...) is written. In forward fill (`dir_in` = 1), bus lane i, which is bits [6i+5:6i], goes to column 6g+i.
- R4: The cascade enable output is high for exactly one cycle, following clock GROUPS. It is low at every other time.
- R5: No writes happen after GROUPS groups. A start pulse on clock GROUPS+2 is ignored. A start pulse on clock GROUPS+3 or later is accepted.
- R6: With `dir_in` = 1, start is taken from `en_a_in` and the cascade pulse appears on `en_b_out`. With `dir_in` = 0, the roles swap. The unused output stays low, and exactly one of `en_a_oe`/`en_b_oe` is high, marking the output pin.
- R7: In reverse fill (`dir_in` = 0), lane i of group g goes to column COLS-1-(6g+i).
- R8: When `inv_lo` is high, bits 0..2 of every code are inverted before storage. When `inv_hi` is high, bits 3..5 are inverted. Bit 0 is the LSB. Both flags are sampled on the same edge as the bus.
- R9: A start pulse that arrives while a line is loading has no effect on the slot order, the stored data or the cascade timing.
- R10: `line_done` rises after clock GROUPS+1, in the same cycle the cascade pulse ends. It clears when the next start is accepted.
- R11: The direction is captured with the start pulse. A change on `dir_in` during a line does not change that line's column mapping or pin roles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_in | input | 1 | 1: forward fill, A pins in / B pins out; 0: reverse, roles swapped |
| en_a_in | input | 1 | Enable input side of pin pair A |
| en_b_in | input | 1 | Enable input side of pin pair B |
| en_a_out | output | 1 | Cascade pulse on pin pair A |
| en_b_out | output | 1 | Cascade pulse on pin pair B |
| en_a_oe | output | 1 | Pin pair A is the output |
| en_b_oe | output | 1 | Pin pair B is the output |
| inv_lo | input | 1 | Low code half arrives inverted |
| inv_hi | input | 1 | High code half arrives inverted |
| pix_bus | input | LANES*CODE_W | Codes for one group, lane i at [i*CODE_W +: CODE_W] |
| rd_col | input | $clog2(COLS) | Read column index |
| rd_code | output | CODE_W | Stored code at `rd_col` (0 when out of range) |
| line_done | output | 1 | Whole line written |

## Verification
The bench builds the block with COLS = 24 and six 6-bit lanes, which gives four groups per line. At that size every column can be read back after every line. The bench sweeps both fill directions, all four inversion-flag pairs, and flags that change from group to group. The short line also puts the cascade pulse, the trailing ignored clock and back-to-back restarts within a few cycles of one another, so off-by-one counting in any of them moves a checked value.

// File: rtl/colfill_pkg.sv
package colfill_pkg;
   typedef enum logic {
      FILL_DOWN = 1'b0,
      FILL_UP   = 1'b1
   } fill_dir_e;
endpackage

// File: rtl/colfill_ctrl.sv
module colfill_ctrl
   import colfill_pkg::*;
#(
   parameter int GROUPS = 80,
   localparam int CNT_W = $clog2(GROUPS + 3),
   localparam int GW    = $clog2(GROUPS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dir_in,
   input  logic          start_a,
   input  logic          start_b,
   output logic          busy,
   output fill_dir_e     dir_q,
   output logic          wr_en,
   output logic [GW-1:0] grp,
   output logic          casc_a,
   output logic          casc_b,
   output logic          oe_a,
   output logic          oe_b,
   output logic          done
);
   localparam logic [CNT_W-1:0] C_CASC = CNT_W'(GROUPS - 1);
   localparam logic [CNT_W-1:0] C_LAST = CNT_W'(GROUPS);
   localparam logic [CNT_W-1:0] C_END  = CNT_W'(GROUPS + 1);

   logic [CNT_W-1:0] cnt;
   logic             casc;
   logic             sel_dir;
   logic             accept;

   assign sel_dir = busy ? dir_q : dir_in;
   assign accept  = !busy && (sel_dir ? start_a : start_b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt   <= '0;
         dir_q <= FILL_DOWN;
         casc  <= 1'b0;
         done  <= 1'b0;
      end else begin
         casc <= 1'b0;
         if (accept) begin
            busy  <= 1'b1;
            cnt   <= CNT_W'(1);
            dir_q <= fill_dir_e'(dir_in);
            done  <= 1'b0;
         end else if (busy) begin
            cnt <= cnt + CNT_W'(1);
            if (cnt == C_CASC) casc <= 1'b1;
            if (cnt == C_LAST) done <= 1'b1;
            if (cnt == C_END)  busy <= 1'b0;
         end
      end
   end

   assign wr_en  = busy && (cnt != '0) && (cnt <= C_LAST);
   assign grp    = GW'(cnt - CNT_W'(1));
   assign casc_a = casc && (dir_q == FILL_DOWN);
   assign casc_b = casc && (dir_q == FILL_UP);
   assign oe_a   = !sel_dir;
   assign oe_b   = sel_dir;
endmodule

// File: rtl/colfill_unflip.sv
module colfill_unflip #(
   parameter int CODE_W = 6,
   parameter int LANES  = 6,
   localparam int HI_W  = CODE_W / 2,
   localparam int LO_W  = CODE_W - HI_W,
   localparam int BUS_W = LANES * CODE_W
) (
   input  logic [BUS_W-1:0] bus_in,
   input  logic             inv_lo,
   input  logic             inv_hi,
   output logic [BUS_W-1:0] bus_out
);
   logic [CODE_W-1:0] mask;
   assign mask = {{HI_W{inv_hi}}, {LO_W{inv_lo}}};

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign bus_out[i*CODE_W +: CODE_W] = bus_in[i*CODE_W +: CODE_W] ^ mask;
   end
endmodule

// File: rtl/colfill_linebuf.sv
module colfill_linebuf
   import colfill_pkg::*;
#(
   parameter int CODE_W = 6,
   parameter int LANES  = 6,
   parameter int COLS   = 480,
   localparam int GROUPS = COLS / LANES,
   localparam int GW     = $clog2(GROUPS),
   localparam int AW     = $clog2(COLS),
   localparam int BUS_W  = LANES * CODE_W
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [GW-1:0]     grp,
   input  fill_dir_e         dir_q,
   input  logic [BUS_W-1:0]  codes,
   input  logic [AW-1:0]     rd_col,
   output logic [CODE_W-1:0] rd_code
);
   logic [CODE_W-1:0] mem [COLS];
   logic [AW-1:0]     col_w [LANES];

   for (genvar i = 0; i < LANES; i++) begin : g_addr
      logic [AW-1:0] base;
      assign base     = AW'(grp) * AW'(LANES) + AW'(i);
      assign col_w[i] = (dir_q == FILL_UP) ? base : AW'(COLS - 1) - base;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int i = 0; i < LANES; i++) begin
            mem[col_w[i]] <= codes[i*CODE_W +: CODE_W];
         end
      end
   end

   assign rd_code = (32'(rd_col) < COLS) ? mem[rd_col] : '0;
endmodule

// File: rtl/colfill_seq.sv
module colfill_seq
   import colfill_pkg::*;
#(
   parameter int CODE_W = 6,
   parameter int LANES  = 6,
   parameter int COLS   = 480,
   localparam int GROUPS = COLS / LANES,
   localparam int GW     = $clog2(GROUPS),
   localparam int AW     = $clog2(COLS),
   localparam int BUS_W  = LANES * CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_in,
   input  logic              en_a_in,
   input  logic              en_b_in,
   output logic              en_a_out,
   output logic              en_b_out,
   output logic              en_a_oe,
   output logic              en_b_oe,
   input  logic              inv_lo,
   input  logic              inv_hi,
   input  logic [BUS_W-1:0]  pix_bus,
   input  logic [AW-1:0]     rd_col,
   output logic [CODE_W-1:0] rd_code,
   output logic              line_done
);
   if (CODE_W < 2) begin : g_bad_code
      $error("colfill_seq: CODE_W must be at least 2");
   end
   if (COLS % LANES != 0) begin : g_bad_cols
      $error("colfill_seq: COLS must be a multiple of LANES");
   end
   if (GROUPS < 2) begin : g_bad_groups
      $error("colfill_seq: at least two groups per line are needed");
   end

   logic             busy;
   fill_dir_e        dir_q;
   logic             wr_en;
   logic [GW-1:0]    grp;
   logic [BUS_W-1:0] true_bus;

   colfill_ctrl #(.GROUPS(GROUPS)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .dir_in (dir_in),
      .start_a(en_a_in),
      .start_b(en_b_in),
      .busy   (busy),
      .dir_q  (dir_q),
      .wr_en  (wr_en),
      .grp    (grp),
      .casc_a (en_a_out),
      .casc_b (en_b_out),
      .oe_a   (en_a_oe),
      .oe_b   (en_b_oe),
      .done   (line_done)
   );

   colfill_unflip #(.CODE_W(CODE_W), .LANES(LANES)) u_unflip (
      .bus_in (pix_bus),
      .inv_lo (inv_lo),
      .inv_hi (inv_hi),
      .bus_out(true_bus)
   );

   colfill_linebuf #(.CODE_W(CODE_W), .LANES(LANES), .COLS(COLS)) u_buf (
      .clk    (clk),
      .wr_en  (wr_en),
      .grp    (grp),
      .dir_q  (dir_q),
      .codes  (true_bus),
      .rd_col (rd_col),
      .rd_code(rd_code)
   );
endmodule

// File: rtl/colfill_chk.sv
module colfill_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic line_done,
   input logic en_a_out,
   input logic en_b_out,
   input logic en_a_oe,
   input logic en_b_oe
);
   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!line_done && !en_a_out && !en_b_out));

   // R4
   casc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_a_out || en_b_out) |=> !(en_a_out || en_b_out));

   // R6
   casc_a_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_a_out |-> (en_a_oe && !en_b_out));

   // R6
   casc_b_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_b_out |-> (en_b_oe && !en_a_out));

   // R10
   done_after_casc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_done) |-> $fell(en_a_out || en_b_out));

   // R5
   idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> line_done);

   // R10
   start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !line_done);
endmodule

bind colfill_seq colfill_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .line_done(line_done),
   .en_a_out (en_a_out),
   .en_b_out (en_b_out),
   .en_a_oe  (en_a_oe),
   .en_b_oe  (en_b_oe)
);

// File: tb/colfill_seq_bench.sv
module colfill_seq_bench;
   localparam int PERIOD = 10;
   localparam int CODE_W = 6;
   localparam int LANES  = 6;
   localparam int COLS   = 24;
   localparam int G      = COLS / LANES;
   localparam int AW     = $clog2(COLS);
   localparam int BUS_W  = LANES * CODE_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              dir_in = 1'b1;
   logic              en_a_in = 1'b0;
   logic              en_b_in = 1'b0;
   logic              en_a_out, en_b_out, en_a_oe, en_b_oe;
   logic              inv_lo = 1'b0;
   logic              inv_hi = 1'b0;
   logic [BUS_W-1:0]  pix_bus = '0;
   logic [AW-1:0]     rd_col = '0;
   logic [CODE_W-1:0] rd_code;
   logic              line_done;

   int n_chk = 0;
   int n_bad = 0;

   always #(PERIOD/2) clk = ~clk;

   colfill_seq #(.CODE_W(CODE_W), .LANES(LANES), .COLS(COLS)) u_colfill_seq (
      .clk(clk), .rst_n(rst_n), .dir_in(dir_in),
      .en_a_in(en_a_in), .en_b_in(en_b_in),
      .en_a_out(en_a_out), .en_b_out(en_b_out),
      .en_a_oe(en_a_oe), .en_b_oe(en_b_oe),
      .inv_lo(inv_lo), .inv_hi(inv_hi), .pix_bus(pix_bus),
      .rd_col(rd_col), .rd_code(rd_code), .line_done(line_done)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   function automatic int tval(int k, int g, int i);
      return (k * 7 + g * 11 + i * 5 + 3) & 63;
   endfunction

   function automatic logic flag_lo(int k, int g);
      return logic'((k + g) & 1);
   endfunction

   function automatic logic flag_hi(int k, int g);
      return logic'(((k >> 1) + (g >> 1)) & 1);
   endfunction

   task automatic set_start(input logic d, input logic v);
      if (d) en_a_in = v; else en_b_in = v;
   endtask

   task automatic check_casc(input logic d, input int exp, input string req);
      check(req, int'(d ? en_b_out : en_a_out), exp);
      check({req, " idle pin"}, int'(d ? en_a_out : en_b_out), 0);
   endtask

   // R2: start sampled on clock 1, nothing else happens on that clock
   task automatic drive_start(input logic d);
      dir_in = d;
      set_start(d, 1'b1);
      pix_bus = '1;
      step();
      set_start(d, 1'b0);
      check_casc(d, 0, "R4 after start");
   endtask

   task automatic data_phase(input logic d, input int k, input bit mid_start, input bit mid_dir);
      for (int g = 0; g < G; g++) begin
         logic lo, hi;
         lo = flag_lo(k, g);
         hi = flag_hi(k, g);
         inv_lo = lo;
         inv_hi = hi;
         for (int i = 0; i < LANES; i++) begin
            pix_bus[i*CODE_W +: CODE_W] = CODE_W'(tval(k, g, i)) ^ {{3{hi}}, {3{lo}}};
         end
         if (mid_start && g == 1) set_start(d, 1'b1);   // R9
         if (mid_dir && g == 2) dir_in = ~d;             // R11
         step();
         set_start(d, 1'b0);
         if (mid_start) set_start(~d, 1'b0);
         check_casc(d, (g == G - 2) ? 1 : 0, "R4 cascade timing");
         check("R11 pin role held", int'(d ? en_b_oe : en_a_oe), 1);
         check("R10 done timing", int'(line_done), (g == G - 1) ? 1 : 0);
      end
      dir_in = d;
      inv_lo = 1'b0;
      inv_hi = 1'b0;
      pix_bus = '0;
   endtask

   // R3 R7 R8: every column read back through the read port
   task automatic verify(input logic d, input int k, input string req);
      for (int g = 0; g < G; g++) begin
         for (int i = 0; i < LANES; i++) begin
            int col;
            col = d ? (g * LANES + i) : (COLS - 1 - (g * LANES + i));
            rd_col = AW'(col);
            #1;
            check(req, int'(rd_code), tval(k, g, i));
         end
      end
   endtask

   initial begin
      #(PERIOD * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      step(); step(); step();
      // R1
      check("R1 en_a_out", int'(en_a_out), 0);
      check("R1 en_b_out", int'(en_b_out), 0);
      check("R1 line_done", int'(line_done), 0);
      check("R1 en_b_oe", int'(en_b_oe), 1);
      check("R1 en_a_oe", int'(en_a_oe), 0);
      rst_n = 1'b1;
      step();
      check("R1 after release", int'(line_done || en_a_out || en_b_out), 0);

      // R6: the wrong pin must not start a line
      dir_in = 1'b1;
      en_b_in = 1'b1;
      step();
      en_b_in = 1'b0;
      step(); step(); step(); step(); step(); step();
      check("R6 wrong pin ignored", int'(line_done || en_a_out || en_b_out), 0);

      // R3 R7 R8: sweep directions and flag patterns
      for (int k = 0; k < 8; k++) begin
         logic d;
         d = logic'(k & 1);
         drive_start(d);
         check("R6 output enable", int'(d ? en_b_oe : en_a_oe), 1);
         data_phase(d, k, 1'b0, 1'b0);
         step();
         verify(d, k, d ? "R3 R8 forward" : "R7 R8 reverse");
      end

      // R9 and R11: restart attempt and direction change mid-line
      drive_start(1'b1);
      data_phase(1'b1, 9, 1'b1, 1'b1);
      step();
      verify(1'b1, 9, "R9 R11 forward");
      drive_start(1'b0);
      data_phase(1'b0, 10, 1'b1, 1'b1);
      step();
      verify(1'b0, 10, "R9 R11 reverse");

      // R5: start on clock G+2 ignored, on clock G+3 accepted
      drive_start(1'b1);
      data_phase(1'b1, 11, 1'b0, 1'b0);
      en_a_in = 1'b1;
      step();
      check("R5 trailing start ignored", int'(line_done), 1);
      step();
      en_a_in = 1'b0;
      check("R5 R10 next start accepted", int'(line_done), 0);
      data_phase(1'b1, 12, 1'b0, 1'b0);
      step();
      verify(1'b1, 12, "R5 back-to-back");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule